// File: doc/BRIEF.md
# LVDS Display 1:7 Receiver Aligner

This block sits behind the sampling front end of a flat-panel video link. It takes one bit per cycle from the clock lane and from each of four data lanes, at seven bit times per pixel. Each lane carries a seven-slot word. The aligner finds where each word starts by looking for the fixed shape of the clock lane. Once it has found that boundary reliably, it rebuilds one parallel pixel per word: 8-bit red, green and blue, plus horizontal sync, vertical sync and data enable.

Three lane-to-colour mappings can be selected at run time: an 18-bit mapping on three lanes, and two 24-bit mappings on four lanes. One 24-bit mapping puts the colour high bits on the first three lanes; the other puts the low bits there. A mirror input reverses the slot order of every data lane before the mapping is undone.

The serial side has a qualifier (`in_valid`) but no ready signal, because a video line cannot be stalled. The pixel side is valid-only: `pix_valid` is a one-cycle strobe and the consumer must take the pixel on that cycle. The block applies no back-pressure in either direction. Between strobes the pixel outputs hold their last value.

Top module: `lvds_rx_aligner`

## Requirements
- R1: Word alignment is found at any of the seven sample offsets. A word boundary is declared when the last seven accepted clock-lane samples read 1,1,0,0,0,1,1, where the oldest sample is slot 0.
- R2: After a first match, the block checks the clock pattern every seven accepted samples. `locked` rises when four words in a row match. The fourth matching word produces the first pixel strobe, on the same clock edge as `locked` rises.
- R3: While locked, one non-matching word keeps the lock and its pixel is still strobed. A matching word clears the miss count. A second non-matching word in a row drops `locked`, produces no strobe, and restarts the search.
- R4: `pix_valid` is high for exactly one cycle per decoded word, and only while `locked` is high. It appears on the edge that captures slot 6 of the word.
- R5: A cycle with `in_valid` low is ignored. It does not shift the lanes, move the word phase or produce a strobe, whatever values the lanes carry.
- R6: With `cfg_mode` = 0 (18-bit), lanes 0 to 2 are decoded as follows:
  - Lane 0: slot 0 = G0; slots 1..6 = R5..R0.
  - Lane 1: slots 0,1 = B1,B0; slots 2..6 = G5..G1.
  - Lane 2: slots 0,1,2 = DE,VS,HS; slots 3..6 = B5..B2.
  - Each 6-bit colour becomes the output bits [7:2], and its two MSBs are copied into bits [1:0].
- R7: With `cfg_mode` = 1 (24-bit, high bits first), lanes 0 to 2 use the R6 slot layout but carry colour bits [7:2]. Lane 3 slots 1..6 carry B1,B0,G1,G0,R1,R0.
- R8: With `cfg_mode` = 2 (24-bit, low bits first), lanes 0 to 2 use the R6 slot layout and carry colour bits [5:0]. Lane 3 slots 1..6 carry B7,B6,G7,G6,R7,R6.
- R9: With `cfg_mirror` = 1, each data lane's word is read slot 6 first. Received slot k is treated as mapping slot 6-k.
- R10: Lane 3 slot 0 (a reserved bit, nominally 0) has no effect on the pixel. In mode 0, lane 3 as a whole has no effect.
- R11: During and after reset, `locked` and `pix_valid` are 0 and all pixel outputs are 0.
- R12: When `pix_valid` is low, the pixel outputs hold the value of the last strobed pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial sample clock (seven samples per pixel) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the lane samples of this cycle |
| in_clk_lane | input | 1 | Sample of the clock lane |
| in_data | input | 4 | Samples of data lanes 3..0 |
| cfg_mode | input | 2 | Mapping: 0 = 18-bit, 1 = 24-bit high-first, 2 = 24-bit low-first |
| cfg_mirror | input | 1 | Reverse the slot order on every data lane |
| locked | output | 1 | Word alignment established |
| pix_valid | output | 1 | One-cycle strobe for a decoded pixel |
| pix_r | output | 8 | Red |
| pix_g | output | 8 | Green |
| pix_b | output | 8 | Blue |
| pix_hsync | output | 1 | Horizontal sync |
| pix_vsync | output | 1 | Vertical sync |
| pix_de | output | 1 | Data enable |

## Verification
The lock decision and the pixel strobe are taken on the same clock edge, at each word boundary. Three cases stress this: acquisition (the fourth good word must both raise `locked` and strobe), a first miss (lock held, pixel still strobed), and a second miss (lock dropped, strobe suppressed). The bench sends words whose clock lane is held at zero in chosen positions. It compares `locked`, `pix_valid` and the pixel, at every boundary, with a model built from the lock rules. Random idle cycles carrying random lane values are mixed in, so that a wrongly counted phase would show up as a strobe at the wrong boundary.

// File: rtl/lvds_rx_pkg.sv
package lvds_rx_pkg;

  // one word is seven bit times on every lane
  localparam int SLOTS = 7;

  // clock lane shape across slots 0..6, slot 0 held in the MSB
  localparam logic [SLOTS-1:0] CLK_SHAPE = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_18BIT  = 2'd0,
    MAP_24_HI  = 2'd1,
    MAP_24_LO  = 2'd2
  } map_mode_e;

  typedef enum logic [1:0] {
    AL_SEARCH = 2'd0,
    AL_TRACK  = 2'd1,
    AL_LOCKED = 2'd2
  } align_state_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic       hs;
    logic       vs;
    logic       de;
  } pixel_t;

endpackage

// File: rtl/lvds_rx_slot_window.sv
module lvds_rx_slot_window
  import lvds_rx_pkg::*;
#(
  parameter int LANES = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [LANES-1:0]            in_bits,
  output logic [LANES-1:0][SLOTS-1:0] win_next
);

  // per lane: a seven-deep history, newest sample in bit 0
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [SLOTS-1:0] hist_q;

    assign win_next[ln] = in_valid ? {hist_q[SLOTS-2:0], in_bits[ln]} : hist_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist_q <= '0;
      end else if (in_valid) begin
        hist_q <= win_next[ln];
      end
    end
  end

endmodule

// File: rtl/lvds_rx_word_lock.sv
module lvds_rx_word_lock
  import lvds_rx_pkg::*;
#(
  parameter int LOCK_WORDS = 4,
  parameter int MISS_WORDS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SLOTS-1:0] clk_win,
  output logic             word_strobe,
  output logic             locked
);

  localparam int GW = $clog2(LOCK_WORDS + 1);
  localparam int MW = $clog2(MISS_WORDS + 1);
  localparam int PW = $clog2(SLOTS);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_WORDS - 1);
  localparam logic [MW-1:0] MISS_LAST = MW'(MISS_WORDS - 1);
  localparam logic [PW-1:0] PHASE_END = PW'(SLOTS - 1);

  align_state_e  state_q, state_n;
  logic [PW-1:0] phase_q, phase_n;
  logic [GW-1:0] good_q, good_n;
  logic [MW-1:0] miss_q, miss_n;
  logic          shape_ok;
  logic          at_edge;

  assign shape_ok = (clk_win == CLK_SHAPE);
  assign at_edge  = (state_q != AL_SEARCH) && (phase_q == PHASE_END);

  always_comb begin
    state_n     = state_q;
    phase_n     = phase_q;
    good_n      = good_q;
    miss_n      = miss_q;
    word_strobe = 1'b0;
    if (in_valid) begin
      unique case (state_q)
        AL_SEARCH: begin
          // every accepted sample is a candidate rotation
          if (shape_ok) begin
            phase_n = '0;
            good_n  = GW'(1);
            miss_n  = '0;
            if (LOCK_WORDS <= 1) begin
              state_n     = AL_LOCKED;
              word_strobe = 1'b1;
            end else begin
              state_n = AL_TRACK;
            end
          end
        end
        AL_TRACK: begin
          phase_n = at_edge ? '0 : phase_q + PW'(1);
          if (at_edge) begin
            if (shape_ok) begin
              good_n = good_q + GW'(1);
              if (good_q == GOOD_LAST) begin
                state_n     = AL_LOCKED;
                word_strobe = 1'b1;
              end
            end else begin
              state_n = AL_SEARCH;
              good_n  = '0;
            end
          end
        end
        AL_LOCKED: begin
          phase_n = at_edge ? '0 : phase_q + PW'(1);
          if (at_edge) begin
            if (shape_ok) begin
              miss_n      = '0;
              word_strobe = 1'b1;
            end else if (miss_q == MISS_LAST) begin
              state_n = AL_SEARCH;
              miss_n  = '0;
              good_n  = '0;
            end else begin
              miss_n      = miss_q + MW'(1);
              word_strobe = 1'b1;
            end
          end
        end
        default: begin
          state_n = AL_SEARCH;
          good_n  = '0;
          miss_n  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= AL_SEARCH;
      phase_q <= '0;
      good_q  <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      good_q  <= good_n;
      miss_q  <= miss_n;
    end
  end

  assign locked = (state_q == AL_LOCKED);

endmodule

// File: rtl/lvds_rx_unmap.sv
module lvds_rx_unmap
  import lvds_rx_pkg::*;
#(
  parameter int DATA_LANES = 4
) (
  input  map_mode_e                        mode,
  input  logic                             mirror,
  input  logic [DATA_LANES-1:0][SLOTS-1:0] win,
  output pixel_t                           pix
);

  localparam int TOP = SLOTS - 1;

  // slot view of lanes 0..2, and of lane 3 without its reserved slot 0
  logic [2:0][SLOTS-1:0] sl;
  logic [TOP:1]          l3;

  for (genvar ln = 0; ln < 3; ln++) begin : g_view
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign sl[ln][s] = mirror ? win[ln][s] : win[ln][TOP-s];
    end
  end

  for (genvar s = 1; s < SLOTS; s++) begin : g_l3
    assign l3[s] = mirror ? win[3][s] : win[3][TOP-s];
  end

  logic [5:0] c6r, c6g, c6b;
  logic [1:0] pr, pg, pb;

  always_comb begin
    for (int j = 0; j < 6; j++) begin
      c6r[j] = sl[0][6-j];
    end
    c6g[0] = sl[0][0];
    for (int j = 1; j < 6; j++) begin
      c6g[j] = sl[1][7-j];
    end
    c6b[0] = sl[1][1];
    c6b[1] = sl[1][0];
    for (int j = 2; j < 6; j++) begin
      c6b[j] = sl[2][8-j];
    end
    pr = {l3[5], l3[6]};
    pg = {l3[3], l3[4]};
    pb = {l3[1], l3[2]};
  end

  always_comb begin
    pix.de = sl[2][0];
    pix.vs = sl[2][1];
    pix.hs = sl[2][2];
    unique case (mode)
      MAP_24_HI: begin
        pix.r = {c6r, pr};
        pix.g = {c6g, pg};
        pix.b = {c6b, pb};
      end
      MAP_24_LO: begin
        pix.r = {pr, c6r};
        pix.g = {pg, c6g};
        pix.b = {pb, c6b};
      end
      default: begin
        pix.r = {c6r, c6r[5:4]};
        pix.g = {c6g, c6g[5:4]};
        pix.b = {c6b, c6b[5:4]};
      end
    endcase
  end

endmodule

// File: rtl/lvds_rx_aligner.sv
module lvds_rx_aligner
  import lvds_rx_pkg::*;
#(
  parameter int LOCK_WORDS = 4,
  parameter int MISS_WORDS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_clk_lane,
  input  logic [3:0] in_data,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_mirror,
  output logic       locked,
  output logic       pix_valid,
  output logic [7:0] pix_r,
  output logic [7:0] pix_g,
  output logic [7:0] pix_b,
  output logic       pix_hsync,
  output logic       pix_vsync,
  output logic       pix_de
);

  localparam int DATA_LANES = 4;
  localparam int ALL_LANES  = DATA_LANES + 1;

  logic [ALL_LANES-1:0][SLOTS-1:0] win_next;
  logic                            strobe;
  pixel_t                          decoded;
  pixel_t                          pix_q;
  logic                            valid_q;

  lvds_rx_slot_window #(
    .LANES (ALL_LANES)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bits  ({in_data, in_clk_lane}),
    .win_next (win_next)
  );

  lvds_rx_word_lock #(
    .LOCK_WORDS (LOCK_WORDS),
    .MISS_WORDS (MISS_WORDS)
  ) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .clk_win     (win_next[0]),
    .word_strobe (strobe),
    .locked      (locked)
  );

  lvds_rx_unmap #(
    .DATA_LANES (DATA_LANES)
  ) u_unmap (
    .mode   (map_mode_e'(cfg_mode)),
    .mirror (cfg_mirror),
    .win    (win_next[ALL_LANES-1:1]),
    .pix    (decoded)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= strobe;
      if (strobe) begin
        pix_q <= decoded;
      end
    end
  end

  assign pix_valid = valid_q;
  assign pix_r     = pix_q.r;
  assign pix_g     = pix_q.g;
  assign pix_b     = pix_q.b;
  assign pix_hsync = pix_q.hs;
  assign pix_vsync = pix_q.vs;
  assign pix_de    = pix_q.de;

endmodule

// File: rtl/lvds_rx_aligner_checker.sv
module lvds_rx_aligner_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       locked,
  input logic       pix_valid,
  input logic [7:0] pix_r,
  input logic [7:0] pix_g,
  input logic [7:0] pix_b,
  input logic       pix_hsync,
  input logic       pix_vsync,
  input logic       pix_de
);

  p_strobe_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> locked);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  p_idle_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !pix_valid);

  p_lock_with_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> pix_valid);

  p_unlock_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !pix_valid);

  p_hold_between_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> $stable({pix_r, pix_g, pix_b, pix_hsync, pix_vsync, pix_de}));

endmodule

bind lvds_rx_aligner lvds_rx_aligner_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .locked    (locked),
  .pix_valid (pix_valid),
  .pix_r     (pix_r),
  .pix_g     (pix_g),
  .pix_b     (pix_b),
  .pix_hsync (pix_hsync),
  .pix_vsync (pix_vsync),
  .pix_de    (pix_de)
);

// File: tb/lvds_rx_aligner_tb_top.sv
`timescale 1ns/1ps
module lvds_rx_aligner_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_clk_lane;
  logic [3:0] in_data;
  logic [1:0] cfg_mode;
  logic       cfg_mirror;
  logic       locked;
  logic       pix_valid;
  logic [7:0] pix_r, pix_g, pix_b;
  logic       pix_hsync, pix_vsync, pix_de;

  int  n_checks = 0;
  int  n_errs   = 0;
  bit  finished = 0;
  bit  gaps_on  = 0;

  // reference model of the lock rules
  bit          m_locked;
  int          m_good;
  int          m_miss;
  logic [26:0] m_held;

  always #4 clk = ~clk;

  lvds_rx_aligner dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_clk_lane (in_clk_lane),
    .in_data     (in_data),
    .cfg_mode    (cfg_mode),
    .cfg_mirror  (cfg_mirror),
    .locked      (locked),
    .pix_valid   (pix_valid),
    .pix_r       (pix_r),
    .pix_g       (pix_g),
    .pix_b       (pix_b),
    .pix_hsync   (pix_hsync),
    .pix_vsync   (pix_vsync),
    .pix_de      (pix_de)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // serialise one word per the slot layouts of R6..R10
  function automatic logic [27:0] encode(input logic [7:0] r, input logic [7:0] g,
      input logic [7:0] b, input logic hs, input logic vs, input logic de,
      input logic [1:0] mode, input logic mir, input logic ctl3, input logic [6:0] junk3);
    logic [5:0] cr, cg, cb;
    logic [1:0] pr, pg, pb;
    logic [3:0][6:0] m;
    logic [27:0] o;
    if (mode == 2'd1) begin
      cr = r[7:2]; cg = g[7:2]; cb = b[7:2];
      pr = r[1:0]; pg = g[1:0]; pb = b[1:0];
    end else if (mode == 2'd2) begin
      cr = r[5:0]; cg = g[5:0]; cb = b[5:0];
      pr = r[7:6]; pg = g[7:6]; pb = b[7:6];
    end else begin
      cr = r[7:2]; cg = g[7:2]; cb = b[7:2];
      pr = 2'b00;  pg = 2'b00;  pb = 2'b00;
    end
    m[0][0] = cg[0];
    for (int k = 1; k < 7; k++) m[0][k] = cr[6-k];
    m[1][0] = cb[1];
    m[1][1] = cb[0];
    for (int k = 2; k < 7; k++) m[1][k] = cg[7-k];
    m[2][0] = de;
    m[2][1] = vs;
    m[2][2] = hs;
    for (int k = 3; k < 7; k++) m[2][k] = cb[8-k];
    m[3] = {pr[0], pr[1], pg[0], pg[1], pb[0], pb[1], ctl3};
    if (mode == 2'd0) m[3] = junk3;
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 7; s++)
        o[l*7+s] = mir ? m[l][6-s] : m[l][s];
    return o;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_clk_lane = 1'b0; in_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    m_locked = 0; m_good = 0; m_miss = 0; m_held = '0;
  endtask

  task automatic drive_sample(input logic cb, input logic [3:0] d);
    int idle = gaps_on ? int'($urandom % 3) : 0;
    repeat (idle) begin
      @(negedge clk);
      in_valid = 1'b0; in_clk_lane = 1'($urandom); in_data = 4'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b1; in_clk_lane = cb; in_data = d;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
      input logic hs, input logic vs, input logic de, input logic [1:0] mode,
      input logic mir, input bit good, input logic ctl3, input logic [6:0] junk3);
    logic [27:0] bits;
    logic [6:0]  shape = 7'b1100011;
    logic [26:0] exp_pix;
    bit          exp_v;
    string       dtag;
    @(negedge clk);
    cfg_mode = mode; cfg_mirror = mir;
    bits = encode(r, g, b, hs, vs, de, mode, mir, ctl3, junk3);
    for (int s = 0; s < 7; s++)
      drive_sample(good ? shape[s] : 1'b0,
                   {bits[21+s], bits[14+s], bits[7+s], bits[s]});
    // model update per R2/R3
    exp_v = 0;
    if (good) begin
      if (m_locked) begin m_miss = 0; exp_v = 1; end
      else begin
        m_good++;
        if (m_good >= 4) begin m_locked = 1; m_miss = 0; exp_v = 1; end
      end
    end else begin
      if (m_locked) begin
        m_miss++;
        if (m_miss >= 2) begin m_locked = 0; m_good = 0; m_miss = 0; end
        else exp_v = 1;
      end else m_good = 0;
    end
    exp_pix = (mode == 2'd0) ? {r[7:2], r[7:6], g[7:2], g[7:6], b[7:2], b[7:6], hs, vs, de}
                             : {r, g, b, hs, vs, de};
    if (exp_v) m_held = exp_pix;
    dtag = (mode == 2'd0) ? "R6" : (mode == 2'd1) ? "R7" : "R8";
    if (mir) dtag = {dtag, " R9"};
    dtag = {dtag, " R10 R5"};
    chk(good ? "R2 R4 strobe" : "R3 R4 strobe", 32'(pix_valid), 32'(exp_v));
    chk(good ? "R1 R2 locked" : "R3 locked", 32'(locked), 32'(m_locked));
    chk(exp_v ? dtag : "R12 hold", 32'({pix_r, pix_g, pix_b, pix_hsync, pix_vsync, pix_de}),
        32'(m_held));
  endtask

  task automatic rand_word(input logic [1:0] mode, input logic mir, input bit good);
    send_word(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), mode, mir, good, 1'($urandom), 7'($urandom));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1a7c));
    cfg_mode = 2'd0; cfg_mirror = 1'b0;
    do_reset();
    // R11: reset state
    chk("R11 locked", 32'(locked), 32'd0);
    chk("R11 strobe", 32'(pix_valid), 32'd0);
    chk("R11 pixel", 32'({pix_r, pix_g, pix_b, pix_hsync, pix_vsync, pix_de}), 32'd0);

    // R1 R2: every offset of the word start, with a junk prefix
    for (int off = 0; off < 7; off++) begin
      do_reset();
      for (int p = 0; p < off; p++) drive_sample(1'b0, 4'($urandom));
      for (int w = 0; w < 6; w++) rand_word(2'(off % 3), 1'(off[0]), 1);
    end

    // R3: miss handling while locked, then relock
    do_reset();
    for (int w = 0; w < 5; w++) rand_word(2'd2, 1'b0, 1);
    rand_word(2'd2, 1'b0, 0);
    rand_word(2'd2, 1'b0, 1);
    rand_word(2'd1, 1'b0, 0);
    rand_word(2'd1, 1'b0, 0);
    for (int w = 0; w < 5; w++) rand_word(2'd1, 1'b1, 1);

    // R10: reserved slot set, all-ones and all-zero colours
    send_word(8'hff, 8'h00, 8'hff, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1, 1'b1, 7'h00);
    send_word(8'h00, 8'hff, 8'h00, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 1, 1'b1, 7'h00);
    send_word(8'h81, 8'h42, 8'h24, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1, 1'b1, 7'h7f);

    // constrained random with idle gaps (R5), mode mix and occasional misses
    gaps_on = 1;
    for (int w = 0; w < 160; w++)
      rand_word(2'($urandom % 3), 1'($urandom), ($urandom % 10) != 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule